// File: doc/BRIEF.md
# Signed-Digit Constant Multiplier with Balanced Adder Tree

This block multiplies an unsigned input word by a positive integer constant fixed at elaboration. When the design elaborates, the constant is rewritten as a string of digits drawn from {-1, 0, +1}, where no two adjacent digits are both non-zero. A long run of ones therefore collapses into one addition and one subtraction. Each non-zero digit produces one shifted copy of the input, negated when the digit is -1.

The shifted terms are summed pairwise in a balanced tree. With n non-zero digits the adder depth is ceil(log2 n) rather than n. In every pairwise sum, the operand holding the higher digit positions has all-zero bits below its lowest digit. Those low result bits are therefore wired straight from the other operand, and no adder cells are spent on them. The full-width product leaves the block through an optional output register. That register has a synchronous, active-high reset.

Top module: `csd_const_mult`

## Requirements
- R1: For every input value, including zero and the all-ones word, `p_out` equals the exact product `x_in * CONST_VAL` with no truncation.
- R2: `p_out` is `IN_W + L` bits wide, where `L` is the bit length of `CONST_VAL` (for example, 8 for 221, 4 for 15, 5 for 17 and 7 for 64).
- R3: A constant with a run of ones is formed from signed digits. For example, 15 is built as 16 - 1, and every subtracted term is never positive. The product for 15 is still exact.
- R4: For a power-of-two constant 2^k, the product is the input shifted left by k, and the low k output bits are zero.
- R5: In each pairwise sum, the higher operand is zero below the split position, and the result's low bits come from the lower operand unchanged. For constant 17, `p_out[3:0]` equals `x_in[3:0]`.
- R6: Each intermediate tree sum fits its signed width, and the root of the tree is never negative.
- R7: With `OUT_REG = 1`, the product of the input sampled at one rising edge appears on `p_out` after that edge, which is one cycle of latency.
- R8: With `OUT_REG = 1`, `rst` high at a rising edge clears `p_out` to zero. The input sampled at that edge is discarded.
- R9: With `OUT_REG = 0`, `p_out` follows `x_in` within the same cycle, without waiting for a clock edge, and reset has no effect on it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| x_in | input | IN_W | Unsigned multiplicand |
| p_out | output | IN_W + bit length of CONST_VAL | Full-width product |

## Verification
Two events can fall in the same cycle: the output register capturing a fresh product, and the synchronous reset clearing it. The bench provokes the overlap by raising `rst` at the same falling edge where it presents a new non-zero input. It then expects zero after the next rising edge, which shows that the input captured at that edge was discarded. One cycle later, after reset drops, it expects the exact product of the following input. The combinational instance is checked in the same window to confirm that reset does not touch it.

// File: rtl/csd_pkg.sv
package csd_pkg;

  // Upper bound on the number of signed digits for a 32-bit constant.
  localparam int MAX_DIG = 34;

  // Signed digit at position idx of the non-adjacent recoding of c.
  function automatic int csd_digit(longint c, int idx);
    longint v;
    int     d;
    v = c;
    for (int i = 0; i < MAX_DIG; i++) begin
      if (v[0]) d = v[1] ? -1 : 1;
      else      d = 0;
      v = (v - longint'(d)) >>> 1;
      if (i == idx) return d;
    end
    return 0;
  endfunction

  // Number of non-zero signed digits.
  function automatic int csd_count(longint c);
    int n;
    n = 0;
    for (int i = 0; i < MAX_DIG; i++)
      if (csd_digit(c, i) != 0) n++;
    return n;
  endfunction

  // Bit position of the n-th non-zero digit, counting from the LSB; -1 if absent.
  function automatic int csd_pos(longint c, int n);
    int seen;
    seen = 0;
    for (int i = 0; i < MAX_DIG; i++) begin
      if (csd_digit(c, i) != 0) begin
        if (seen == n) return i;
        seen++;
      end
    end
    return -1;
  endfunction

  // 1 when the n-th non-zero digit is -1.
  function automatic bit csd_is_neg(longint c, int n);
    int p;
    p = csd_pos(c, n);
    if (p < 0) return 1'b0;
    return csd_digit(c, p) < 0;
  endfunction

  // Number of bits needed to hold c.
  function automatic int bit_len(longint c);
    int n;
    n = 0;
    for (int i = 0; i < 63; i++)
      if ((c >>> i) != 0) n = i + 1;
    return n;
  endfunction

  // Lowest digit position below heap node k (leaves sit at np .. 2*np-1).
  function automatic int subtree_low(longint c, int k, int np);
    int kk;
    int p;
    kk = k;
    for (int i = 0; i < 32; i++)
      if (kk < np) kk = kk * 2;
    p = csd_pos(c, kk - np);
    return (p < 0) ? 0 : p;
  endfunction

endpackage

// File: rtl/csd_term_gen.sv
module csd_term_gen
  import csd_pkg::*;
#(
  parameter int          IN_W      = 8,
  parameter int          TW        = 18,
  parameter int          NP        = 4,
  parameter int unsigned CONST_VAL = 221
) (
  input  logic [IN_W-1:0]        x,
  output logic signed [TW-1:0]   terms [NP]
);

  localparam int N_NZ = csd_count(longint'(CONST_VAL));

  logic signed [TW-1:0] ext;
  assign ext = signed'({{(TW-IN_W){1'b0}}, x});

  for (genvar i = 0; i < NP; i++) begin : g_term
    if (i < N_NZ) begin : g_live
      localparam int POS = csd_pos(longint'(CONST_VAL), i);
      localparam bit NEG = csd_is_neg(longint'(CONST_VAL), i);
      logic signed [TW-1:0] shifted;
      assign shifted = ext <<< POS;
      if (NEG) begin : g_sub
        assign terms[i] = -shifted;
        always_comb begin
          a_r3_sub_term_nonpos : assert (!(terms[i] > 0))
            else $error("subtracted term became positive");
        end
      end else begin : g_add
        assign terms[i] = shifted;
      end
    end else begin : g_pad
      assign terms[i] = '0;
    end
  end

endmodule

// File: rtl/csd_pair_add.sv
module csd_pair_add #(
  parameter int TW  = 18,
  parameter int LOW = 0
) (
  input  logic signed [TW-1:0] lo_op,
  input  logic signed [TW-1:0] hi_op,
  output logic signed [TW-1:0] sum
);

  if (LOW > 0) begin : g_bypass
    // Bits under the split are wired from the lower operand.
    assign sum[LOW-1:0]  = lo_op[LOW-1:0];
    assign sum[TW-1:LOW] = hi_op[TW-1:LOW] + lo_op[TW-1:LOW];
    always_comb begin
      a_r5_hi_low_clear : assert (hi_op[LOW-1:0] == '0)
        else $error("higher operand has bits under the split");
    end
  end else begin : g_full
    assign sum = hi_op + lo_op;
  end

endmodule

// File: rtl/csd_adder_tree.sv
module csd_adder_tree
  import csd_pkg::*;
#(
  parameter int          TW        = 18,
  parameter int          NP        = 4,
  parameter int unsigned CONST_VAL = 221
) (
  input  logic signed [TW-1:0] terms [NP],
  output logic signed [TW-1:0] root
);

  // Heap layout: node 1 is the root, leaves occupy NP .. 2*NP-1.
  logic signed [TW-1:0] node [1:2*NP-1];

  for (genvar i = 0; i < NP; i++) begin : g_leaf
    assign node[NP+i] = terms[i];
  end

  for (genvar k = 1; k < NP; k++) begin : g_node
    localparam int SPLIT = subtree_low(longint'(CONST_VAL), 2*k+1, NP);
    csd_pair_add #(
      .TW  (TW),
      .LOW (SPLIT)
    ) u_add (
      .lo_op (node[2*k]),
      .hi_op (node[2*k+1]),
      .sum   (node[k])
    );
  end

  assign root = node[1];

  always_comb begin
    a_r6_root_nonneg : assert (!root[TW-1])
      else $error("tree root is negative");
  end

endmodule

// File: rtl/csd_const_mult.sv
module csd_const_mult
  import csd_pkg::*;
#(
  parameter int          IN_W      = 8,
  parameter int unsigned CONST_VAL = 221,
  parameter bit          OUT_REG   = 1'b1,
  localparam int         OUT_W     = IN_W + bit_len(longint'(CONST_VAL))
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IN_W-1:0]  x_in,
  output logic [OUT_W-1:0] p_out
);

  localparam int N_NZ = csd_count(longint'(CONST_VAL));
  localparam int LV   = (N_NZ > 1) ? $clog2(N_NZ) : 0;
  localparam int NP   = 1 << LV;
  localparam int TW   = OUT_W + 2;
  localparam logic [OUT_W-1:0] C_EXT = OUT_W'(CONST_VAL);

  logic signed [TW-1:0] terms [NP];
  logic signed [TW-1:0] root;
  logic [OUT_W-1:0]     prod;

  csd_term_gen #(
    .IN_W      (IN_W),
    .TW        (TW),
    .NP        (NP),
    .CONST_VAL (CONST_VAL)
  ) u_terms (
    .x     (x_in),
    .terms (terms)
  );

  csd_adder_tree #(
    .TW        (TW),
    .NP        (NP),
    .CONST_VAL (CONST_VAL)
  ) u_tree (
    .terms (terms),
    .root  (root)
  );

  assign prod = root[OUT_W-1:0];

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) p_out <= '0;
      else     p_out <= prod;
    end

    a_r7_one_cycle_product : assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> p_out == OUT_W'(OUT_W'($past(x_in)) * C_EXT))
      else $error("registered product mismatch");

    a_r8_reset_clears : assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> p_out == '0)
      else $error("output not cleared by reset");
  end else begin : g_comb
    assign p_out = prod;

    a_r9_comb_product : assert property (@(posedge clk) disable iff (rst)
      p_out == OUT_W'(OUT_W'(x_in) * C_EXT))
      else $error("combinational product mismatch");
  end

endmodule

// File: tb/csd_const_mult_test.sv
module csd_const_mult_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  x   = 8'hFF;
  logic [11:0] xw  = 12'h0;

  logic [15:0] p221;
  logic [11:0] p15;
  logic [12:0] p17;
  logic [14:0] p64;
  logic [32:0] pw;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  localparam longint CW = 1768559;

  always #10 clk = ~clk;

  csd_const_mult #(.IN_W(8),  .CONST_VAL(221), .OUT_REG(1'b1)) uut
    (.clk(clk), .rst(rst), .x_in(x),  .p_out(p221));
  csd_const_mult #(.IN_W(8),  .CONST_VAL(15),  .OUT_REG(1'b1)) uut_c15
    (.clk(clk), .rst(rst), .x_in(x),  .p_out(p15));
  csd_const_mult #(.IN_W(8),  .CONST_VAL(17),  .OUT_REG(1'b0)) uut_c17
    (.clk(clk), .rst(rst), .x_in(x),  .p_out(p17));
  csd_const_mult #(.IN_W(8),  .CONST_VAL(64),  .OUT_REG(1'b1)) uut_c64
    (.clk(clk), .rst(rst), .x_in(x),  .p_out(p64));
  csd_const_mult #(.IN_W(12), .CONST_VAL(32'(CW)), .OUT_REG(1'b1)) uut_wide
    (.clk(clk), .rst(rst), .x_in(xw), .p_out(pw));

  function automatic int blen(longint c);
    int n = 0;
    for (int i = 0; i < 63; i++) if ((c >> i) != 0) n = i + 1;
    return n;
  endfunction

  task automatic check(string req, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_regs(logic [7:0] xv);
    check("R1 c221", longint'(p221), longint'(xv) * 221);
    check("R3 c15",  longint'(p15),  longint'(xv) * 15);
    check("R4 c64",  longint'(p64),  longint'(xv) * 64);
    check("R4 c64 low zero", longint'(p64[5:0]), 0);
  endtask

  task automatic check_comb(logic [7:0] xv);
    check("R9 c17 comb", longint'(p17), longint'(xv) * 17);
    check("R5 c17 low wired", longint'(p17[3:0]), longint'(xv[3:0]));
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    logic [7:0]  xp;
    logic [11:0] xwp;
    void'($urandom(32'd4242));

    // R2: widths seen at the ports
    check("R2 width c221", $bits(p221), 8 + blen(221));
    check("R2 width c15",  $bits(p15),  8 + blen(15));
    check("R2 width c17",  $bits(p17),  8 + blen(17));
    check("R2 width c64",  $bits(p64),  8 + blen(64));
    check("R2 width wide", $bits(pw),   12 + blen(CW));

    // Reset held with all-ones input present: R8
    repeat (3) @(negedge clk);
    check("R8 reset c221", longint'(p221), 0);
    check("R8 reset c15",  longint'(p15),  0);
    check("R8 reset c64",  longint'(p64),  0);
    check("R8 reset wide", longint'(pw),   0);
    check_comb(x);
    rst = 1'b0;
    xp  = x;

    // Exhaustive 8-bit sweep; R1 covers 0 and all-ones, R6 via exact results
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      check_regs(xp);
      x = 8'(i);
      #1;
      check_comb(x);
      xp = x;
    end
    @(negedge clk);
    check_regs(xp);

    // Reset coincides with a new input: R8 wins, then R7 latency
    rst = 1'b1;
    x   = 8'hAB;
    #1;
    check_comb(x);
    @(negedge clk);
    check("R8 collide c221", longint'(p221), 0);
    check("R8 collide c15",  longint'(p15),  0);
    check("R8 collide c64",  longint'(p64),  0);
    rst = 1'b0;
    x   = 8'h5C;
    @(negedge clk);
    check("R7 after reset c221", longint'(p221), 64'h5C * 221);
    check("R7 after reset c15",  longint'(p15),  64'h5C * 15);

    // Wide constant, random plus corners (R1, R6)
    xw  = 12'hFFF;
    xwp = xw;
    for (int i = 0; i < 1200; i++) begin
      @(negedge clk);
      check("R1 wide", longint'(pw), longint'(xwp) * CW);
      if (i == 1)      xw = 12'h000;
      else if (i == 2) xw = 12'h800;
      else             xw = 12'($urandom);
      xwp = xw;
    end
    @(negedge clk);
    check("R1 wide last", longint'(pw), longint'(xwp) * CW);

    done = 1'b1;
    summary();
  end

  initial begin
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
    end
  end

endmodule